// File: doc/BRIEF.md
# Bounded Multi-Strip Hit Selector

The selector takes one bunch crossing's worth of strip-hit information from a 127-strip sensor row and reduces it to at most eight fixed-width result words. Each strip supplies a hit bit, a 5-bit segment position that says where along the strip the first hit sat, and a flag that marks additional hits on that strip. The strips are split into groups of eight. Each group counts its own hits, and those counts are chained from the lowest group to the highest. The running total gives every hit a slot number, so the hit with the lowest strip address takes slot 0.

A crossing is marked by `bxValid`. The block samples the strip inputs on that edge and presents a complete frame one edge later. A frame holds eight 13-bit words, a valid bit per slot and an overflow bit. Nothing is carried from one crossing to the next. When a crossing has more than eight hits, the eight lowest-addressed strips are kept, the rest are dropped and the overflow bit is raised. Latency is fixed, so a downstream serializer can rely on a known alignment between the crossing and its frame.

Top module: `hit_selector`

## Requirements
- R1: When `bxValid` is high at a rising edge, the frame for those inputs appears at the next rising edge. `frameValid` is high for exactly that one cycle for each marked crossing.
- R2: Each word is `{strip address [12:6], segment position [5:1], multi-hit flag [0]}`. Slot s occupies bits `[13*s+12 : 13*s]` of `slotWords`. The strip address is the strip index 0..126, and position and flag are copied from that strip's inputs.
- R3: Hits fill slots in strictly ascending strip-address order, across all group boundaries, starting at slot 0.
- R4: `slotValid[s]` is 1 exactly when the crossing has at least s+1 hits. With exactly eight hits, all slots are valid and `overflow` stays 0.
- R5: With more than eight hits, `overflow` is 1, the eight lowest-addressed hits fill the slots and every higher-addressed hit is dropped.
- R6: A slot whose valid bit is 0 carries an all-zero word.
- R7: After reset, `frameValid`, `overflow`, `slotValid` and every word are 0.
- R8: Crossings marked on consecutive cycles each produce their own frame on consecutive cycles, with no hit count carried between them.
- R9: While `bxValid` is low, changes on the strip inputs have no effect: the frame outputs hold their last values and `frameValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bxValid | input | 1 | Marks the current inputs as one bunch crossing |
| hitIn | input | 127 | Hit bit per strip |
| posIn | input | 635 | 5-bit segment position per strip, strip i at [5i+4:5i] |
| flagIn | input | 127 | Multi-hit flag per strip |
| slotWords | output | 104 | Eight 13-bit result words |
| slotValid | output | 8 | Valid bit per slot |
| overflow | output | 1 | More than eight hits in the frame |
| frameValid | output | 1 | New frame present this cycle |

## Verification
Some properties are checked by assertions on every cycle. Valid bits are always a contiguous run from slot 0. Empty slots are zero, and valid slots hold strictly increasing strip addresses. Overflow never appears without all eight slots being full. The two-edge delay from a marked crossing to its frame is also checked this way. Which strips are selected, the word contents and the exact overflow threshold can only be shown by the scenarios. Those scenarios cover empty frames, hits at the two end strips, exactly eight and nine hits, a fully hit array, back-to-back crossings and idle cycles with changing inputs.

// File: rtl/hs_pkg.sv
package hs_pkg;

  // Strobes sent from the sequencing control to the datapath
  typedef struct packed {
    logic capture;   // latch this crossing's strip inputs
    logic publish;   // load the selected words into the frame registers
  } hs_strobe_t;

endpackage

// File: rtl/hs_group_tally.sv
// Counts the hits in one group and gives each member the number of hits below it
module hs_group_tally #(
  parameter int GROUP = 8,
  parameter int CNT_W = 4
) (
  input  logic [GROUP-1:0]       bits,
  output logic [GROUP*CNT_W-1:0] prefix,
  output logic [CNT_W-1:0]       total
);

  always_comb begin
    logic [CNT_W-1:0] run;
    run    = '0;
    prefix = '0;
    for (int j = 0; j < GROUP; j++) begin
      prefix[j*CNT_W +: CNT_W] = run;
      run = run + CNT_W'(bits[j]);
    end
    total = run;
  end

endmodule

// File: rtl/hs_control.sv
// Sequencing: capture on a marked crossing, publish one cycle later
module hs_control (
  input  logic               clk,
  input  logic               rst,
  input  logic               bxValid,
  output hs_pkg::hs_strobe_t strobe
);

  logic pubQ;

  always_ff @(posedge clk) begin
    if (rst) pubQ <= 1'b0;
    else     pubQ <= bxValid;
  end

  assign strobe.capture = bxValid;
  assign strobe.publish = pubQ;

  AST_PUBLISH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> strobe.publish); // R1
  AST_NO_SPURIOUS_PUBLISH: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> !strobe.publish); // R9

endmodule

// File: rtl/hs_datapath.sv
// Input capture, chained group counts, slot selection and frame registers
module hs_datapath #(
  parameter int NUM_STRIPS = 127,
  parameter int GROUP      = 8,
  parameter int SLOTS      = 8,
  parameter int POS_W      = 5
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  hs_pkg::hs_strobe_t                                strobe,
  input  logic [NUM_STRIPS-1:0]                             hitIn,
  input  logic [NUM_STRIPS*POS_W-1:0]                       posIn,
  input  logic [NUM_STRIPS-1:0]                             flagIn,
  output logic [SLOTS*($clog2(NUM_STRIPS)+POS_W+1)-1:0]     slotWords,
  output logic [SLOTS-1:0]                                  slotValid,
  output logic                                              overflow,
  output logic                                              frameValid
);

  localparam int ADDR_W     = $clog2(NUM_STRIPS);
  localparam int WORD_W     = ADDR_W + POS_W + 1;
  localparam int NUM_GROUPS = (NUM_STRIPS + GROUP - 1) / GROUP;
  localparam int PAD        = NUM_GROUPS * GROUP;
  localparam int PRE_W      = $clog2(GROUP + 1);
  localparam int RANK_W     = $clog2(PAD + 1);

  // Captured crossing
  logic [NUM_STRIPS-1:0]       capHit;
  logic [NUM_STRIPS*POS_W-1:0] capPos;
  logic [NUM_STRIPS-1:0]       capFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      capHit  <= '0;
      capPos  <= '0;
      capFlag <= '0;
    end else if (strobe.capture) begin
      capHit  <= hitIn;
      capPos  <= posIn;
      capFlag <= flagIn;
    end
  end

  // Padded strip view and per-strip candidate word
  logic [PAD-1:0]    padHit;
  logic [WORD_W-1:0] candWord [PAD];

  for (genvar i = 0; i < PAD; i++) begin : g_strip
    if (i < NUM_STRIPS) begin : g_real
      assign padHit[i]   = capHit[i];
      assign candWord[i] = {ADDR_W'(i), capPos[i*POS_W +: POS_W], capFlag[i]};
    end else begin : g_pad
      assign padHit[i]   = 1'b0;
      assign candWord[i] = '0;
    end
  end

  // Group counts chained with carry into a running base
  logic [RANK_W-1:0] groupBase [NUM_GROUPS+1];
  logic [RANK_W-1:0] rank      [PAD];

  assign groupBase[0] = '0;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic [GROUP*PRE_W-1:0] pre;
    logic [PRE_W-1:0]       cnt;

    hs_group_tally #(.GROUP(GROUP), .CNT_W(PRE_W)) u_tally (
      .bits   (padHit[g*GROUP +: GROUP]),
      .prefix (pre),
      .total  (cnt)
    );

    assign groupBase[g+1] = groupBase[g] + RANK_W'(cnt);

    for (genvar j = 0; j < GROUP; j++) begin : g_member
      assign rank[g*GROUP + j] = groupBase[g] + RANK_W'(pre[j*PRE_W +: PRE_W]);
    end
  end

  // Slot selection: each slot takes the hit whose rank equals its index
  logic [WORD_W-1:0] nextWord [SLOTS];
  logic [SLOTS-1:0]  nextValid;
  logic              nextOvf;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      nextWord[s]  = '0;
      nextValid[s] = 1'b0;
      for (int i = 0; i < PAD; i++) begin
        if (padHit[i] && rank[i] == RANK_W'(s)) begin
          nextWord[s]  = nextWord[s] | candWord[i];
          nextValid[s] = 1'b1;
        end
      end
    end
    nextOvf = groupBase[NUM_GROUPS] > RANK_W'(SLOTS);
  end

  // Frame registers
  always_ff @(posedge clk) begin
    if (rst) begin
      slotWords  <= '0;
      slotValid  <= '0;
      overflow   <= 1'b0;
      frameValid <= 1'b0;
    end else begin
      frameValid <= strobe.publish;
      if (strobe.publish) begin
        for (int s = 0; s < SLOTS; s++) slotWords[s*WORD_W +: WORD_W] <= nextWord[s];
        slotValid <= nextValid;
        overflow  <= nextOvf;
      end
    end
  end

  // Frame-level checks
  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (rst)
    (slotValid & (slotValid + SLOTS'(1))) == '0); // R4
  AST_OVF_IMPLIES_FULL: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (&slotValid)); // R5
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strobe.publish |=> $stable(slotWords) && $stable(slotValid) && $stable(overflow)); // R9

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
      !slotValid[s] |-> slotWords[s*WORD_W +: WORD_W] == '0); // R6
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
      slotValid[s] |-> slotWords[s*WORD_W + POS_W + 1 +: ADDR_W] < ADDR_W'(NUM_STRIPS)); // R2
    if (s + 1 < SLOTS) begin : g_order
      AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        slotValid[s+1] |-> slotWords[(s+1)*WORD_W + POS_W + 1 +: ADDR_W]
                         > slotWords[s*WORD_W + POS_W + 1 +: ADDR_W]); // R3
    end
  end

endmodule

// File: rtl/hit_selector.sv
module hit_selector #(
  parameter int NUM_STRIPS = 127,
  parameter int GROUP      = 8,
  parameter int SLOTS      = 8,
  parameter int POS_W      = 5
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          bxValid,
  input  logic [NUM_STRIPS-1:0]                         hitIn,
  input  logic [NUM_STRIPS*POS_W-1:0]                   posIn,
  input  logic [NUM_STRIPS-1:0]                         flagIn,
  output logic [SLOTS*($clog2(NUM_STRIPS)+POS_W+1)-1:0] slotWords,
  output logic [SLOTS-1:0]                              slotValid,
  output logic                                          overflow,
  output logic                                          frameValid
);

  hs_pkg::hs_strobe_t strobe;

  hs_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bxValid (bxValid),
    .strobe  (strobe)
  );

  hs_datapath #(
    .NUM_STRIPS (NUM_STRIPS),
    .GROUP      (GROUP),
    .SLOTS      (SLOTS),
    .POS_W      (POS_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .hitIn      (hitIn),
    .posIn      (posIn),
    .flagIn     (flagIn),
    .slotWords  (slotWords),
    .slotValid  (slotValid),
    .overflow   (overflow),
    .frameValid (frameValid)
  );

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bxValid |=> ##1 frameValid); // R1

endmodule

// File: tb/tb_hit_selector.sv
module tb_hit_selector;

  localparam int NS = 127;
  localparam int PW = 5;
  localparam int WW = 13;
  localparam int NSLOT = 8;

  typedef struct packed {
    logic [NSLOT*WW-1:0] words;
    logic [NSLOT-1:0]    valid;
    logic                ovf;
    logic [31:0]         due;
  } exp_t;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 bxValid = 1'b0;
  logic [NS-1:0]        hitIn = '0;
  logic [NS*PW-1:0]     posIn = '0;
  logic [NS-1:0]        flagIn = '0;
  logic [NSLOT*WW-1:0]  slotWords;
  logic [NSLOT-1:0]     slotValid;
  logic                 overflow;
  logic                 frameValid;

  int   nChecks = 0;
  int   nFails  = 0;
  logic [31:0] cyc = 0;
  bit   finished = 0;
  exp_t expQ[$];

  hit_selector dut (
    .clk(clk), .rst(rst), .bxValid(bxValid), .hitIn(hitIn), .posIn(posIn),
    .flagIn(flagIn), .slotWords(slotWords), .slotValid(slotValid),
    .overflow(overflow), .frameValid(frameValid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference selection, written from the requirements
  function automatic exp_t model(input logic [NS-1:0] h, input logic [NS*PW-1:0] p,
                                 input logic [NS-1:0] f);
    exp_t e;
    int n;
    e = '0;
    n = 0;
    for (int i = 0; i < NS; i++) begin
      if (h[i]) begin
        if (n < NSLOT) begin
          e.words[n*WW +: WW] = {7'(i), p[i*PW +: PW], f[i]};
          e.valid[n] = 1'b1;
        end
        n++;
      end
    end
    e.ovf = (n > NSLOT);
    return e;
  endfunction

  function automatic logic [NS*PW-1:0] mkPos(input int k);
    logic [NS*PW-1:0] v;
    for (int i = 0; i < NS; i++) v[i*PW +: PW] = 5'((i * 7 + k) % 32);
    return v;
  endfunction

  // Driver: presents one crossing and queues its expected frame
  task automatic sendFrame(input logic [NS-1:0] h, input logic [NS*PW-1:0] p,
                           input logic [NS-1:0] f);
    exp_t e;
    @(negedge clk);
    hitIn = h; posIn = p; flagIn = f; bxValid = 1'b1;
    e = model(h, p, f);
    e.due = cyc + 2;  // sampled at next edge, published at the one after (R1)
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bxValid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (frameValid) begin
        if (expQ.size() == 0) begin
          check("R9 unexpected frameValid", 128'(frameValid), 128'(0));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check("R1 frame cycle", 128'(cyc), 128'(e.due));
          check("R4 slotValid", 128'(slotValid), 128'(e.valid));
          check("R5 overflow", 128'(overflow), 128'(e.ovf));
          for (int s = 0; s < NSLOT; s++) begin
            if (e.valid[s]) check("R2 R3 slot word", 128'(slotWords[s*WW +: WW]), 128'(e.words[s*WW +: WW]));
            else            check("R6 empty slot word", 128'(slotWords[s*WW +: WW]), 128'(0));
          end
        end
      end else if (expQ.size() != 0 && expQ[0].due == cyc) begin
        check("R1 missing frameValid", 128'(0), 128'(1));
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0]       h;
    logic [NSLOT*WW-1:0] keepW;
    logic [NSLOT-1:0]    keepV;
    logic                keepO;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 frameValid", 128'(frameValid), 128'(0));
    check("R7 slotValid", 128'(slotValid), 128'(0));
    check("R7 overflow", 128'(overflow), 128'(0));
    check("R7 words", 128'(slotWords), 128'(0));

    // Empty crossing
    sendFrame('0, mkPos(1), '0);
    idle(3);
    // Single hits at the two end strips (R2, R3)
    h = '0; h[0] = 1'b1;
    sendFrame(h, mkPos(2), '1);
    idle(3);
    h = '0; h[126] = 1'b1;
    sendFrame(h, {NS{5'd31}}, h);
    idle(3);
    // Exactly eight hits spread over several groups (R4)
    h = '0;
    h[3] = 1; h[9] = 1; h[17] = 1; h[40] = 1; h[63] = 1; h[64] = 1; h[100] = 1; h[126] = 1;
    sendFrame(h, mkPos(5), 127'h5555_5555_5555_5555_5555_5555_5555_5555);
    idle(3);
    // Nine hits: highest one dropped (R5)
    h[120] = 1;
    sendFrame(h, mkPos(6), '0);
    idle(3);
    // Whole array hit (R5)
    sendFrame('1, mkPos(9), 127'h0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F_0F0F);
    idle(3);
    // Back-to-back crossings, no carry between them (R8)
    sendFrame('1, mkPos(11), '0);
    h = '0; h[5] = 1;
    sendFrame(h, mkPos(12), h);
    h = '0; for (int i = 120; i < NS; i++) h[i] = 1'b1;
    sendFrame(h, mkPos(13), '1);
    idle(4);

    // R9: inputs change while bxValid is low
    keepW = slotWords; keepV = slotValid; keepO = overflow;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bxValid = 1'b0;
      hitIn = {$urandom, $urandom, $urandom, $urandom};
      posIn = mkPos(k + 20);
      flagIn = '1;
    end
    @(negedge clk);
    check("R9 frameValid low", 128'(frameValid), 128'(0));
    check("R9 words held", 128'(slotWords), 128'(keepW));
    check("R9 valid held", 128'({keepO, slotValid}), 128'({overflow, keepV}));

    // Mixed sparse and dense crossings, some back-to-back (R3, R4, R5, R8)
    for (int t = 0; t < 40; t++) begin
      h = '0;
      for (int i = 0; i < NS; i++) if (($urandom % 100) < (t % 4 == 0 ? 9 : 4)) h[i] = 1'b1;
      sendFrame(h, mkPos(t), {$urandom, $urandom, $urandom, $urandom});
      if (t % 3 == 0) idle(1);
    end
    idle(5);
    check("R1 all frames delivered", 128'(expQ.size()), 128'(0));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule